// File: doc/BRIEF.md
# Vertical Line Counter for a Raster Video Controller

This block tracks the vertical raster position of a video controller. Each pulse on the line-advance input moves it down one scan line. It supports two frame formats: a 60 Hz format of 262 lines and a 50 Hz format of 313 lines. Internally it keeps a plain linear line index. A mapping stage turns that index into the 8-bit vertical count that software reads.

The count is not a simple modulo counter. Partway through vertical blank it jumps backward, at a different place in each format. The frame still ends on a line that reads 0xFF, and the next line reads 0. In the 50 Hz format the count therefore passes through 0 twice per frame. The vertical-blank flag tells the true frame start apart from the repeat inside blanking.

Besides the count, the block drives the blanking flag, a one-clock frame-start pulse and a 16-bit status word that carries the format and both blanking bits. A change of the format select is applied only where a new frame begins.

Top module: `vline_counter`

## Requirements
- R1: While reset is held, and after it is released, the count reads 0, vertical blank is clear, the frame-start pulse is low and the active format is 60 Hz (status bit 0 reads 0).
- R2: The count and the line position change only in a cycle where the line-advance input is high. In all other cycles they hold.
- R3: In the 60 Hz format the count runs 0x00 up to 0xEA, then 0xE5 up to 0xFF, then back to 0x00. That is 262 advances per frame.
- R4: In the 50 Hz format the count runs 0x00 up to 0xFF, then 0x00 up to 0x02, then 0xCA up to 0xFF, then back to 0x00. That is 313 advances per frame.
- R5: Vertical blank is clear while the count reads 0 to 223 at the start of the frame. It is set from the line that reads 224 through the line that reads 0xFE after the jump, and it is clear again on the final line, which reads 0xFF. In the 50 Hz format the second pass through 0x00 happens with vertical blank set.
- R6: The frame-start pulse goes high for exactly one clock, in the cycle after the advance that takes the line position from the last line back to line 0.
- R7: The format select is sampled only on the advance that starts a new frame. A change made mid-frame leaves the running frame's sequence and status bit 0 unchanged.
- R8: The status word holds the active format in bit 0 (1 = 50 Hz), the horizontal-blank input in bit 2 (passed through with no register) and vertical blank in bit 3. Every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| line_adv | input | 1 | One-cycle strobe that advances one scan line |
| pal_sel | input | 1 | Format select: 1 = 313-line 50 Hz, 0 = 262-line 60 Hz |
| hblank | input | 1 | Horizontal blank, passed into status bit 2 |
| vcount | output | 8 | Visible vertical count |
| vblank | output | 1 | Vertical-blank flag |
| frame_start | output | 1 | One-clock pulse when a new frame begins |
| status | output | 16 | Packed status: bit 0 format, bit 2 horizontal blank, bit 3 vertical blank |

## Verification
The bench builds the block with its default parameters: an 8-bit count, 224 active lines, 262- and 313-line frames, and resume values 0xE5 and 0xCA. With these values both complete line sequences fit in a few thousand clocks, so every line of a 60 Hz frame, a 50 Hz frame and a second 60 Hz frame is compared with an independent sequence model. The format select is switched in the middle of a frame, which puts the deferred format change and the double pass through 0 under test.

// File: rtl/vline_pkg.sv
package vline_pkg;

  typedef enum logic {
    MODE_60HZ = 1'b0,
    MODE_50HZ = 1'b1
  } frame_mode_e;

  localparam int STATUS_W   = 16;
  localparam int ST_PAL_BIT = 0;
  localparam int ST_HB_BIT  = 2;
  localparam int ST_VB_BIT  = 3;

endpackage

// File: rtl/vline_rst_sync.sv
module vline_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/vline_index.sv
module vline_index
  import vline_pkg::*;
#(
  parameter int NTSC_TOTAL = 262,
  parameter int PAL_TOTAL  = 313,
  parameter int IDX_W      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_adv,
  input  logic             pal_sel,
  output logic [IDX_W-1:0] idx,
  output frame_mode_e      mode,
  output logic             frame_start
);

  localparam logic [IDX_W-1:0] NTSC_LAST = IDX_W'(NTSC_TOTAL - 1);
  localparam logic [IDX_W-1:0] PAL_LAST  = IDX_W'(PAL_TOTAL - 1);

  logic [IDX_W-1:0] idx_q, idx_d, last_idx;
  frame_mode_e      mode_q, mode_d;
  logic             wrap, fs_q;

  // next-state
  always_comb begin
    last_idx = (mode_q == MODE_50HZ) ? PAL_LAST : NTSC_LAST;
    wrap     = line_adv && (idx_q == last_idx);
    idx_d    = idx_q;
    mode_d   = mode_q;
    if (line_adv) begin
      if (wrap) begin
        idx_d  = '0;
        mode_d = pal_sel ? MODE_50HZ : MODE_60HZ;
      end else begin
        idx_d  = idx_q + 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      mode_q <= MODE_60HZ;
      fs_q   <= 1'b0;
    end else begin
      if (line_adv) begin
        idx_q  <= idx_d;
        mode_q <= mode_d;
      end
      fs_q <= wrap;
    end
  end

  assign idx         = idx_q;
  assign mode        = mode_q;
  assign frame_start = fs_q;

  AST_IDX_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= last_idx); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !line_adv |=> $stable(idx_q)); // R2
  AST_PULSE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q |-> (idx_q == '0)); // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q |=> !fs_q); // R6
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_q |-> $stable(mode_q)); // R7

endmodule

// File: rtl/vline_map.sv
module vline_map
  import vline_pkg::*;
#(
  parameter int COUNT_W      = 8,
  parameter int IDX_W        = 9,
  parameter int ACTIVE_LINES = 224,
  parameter int NTSC_TOTAL   = 262,
  parameter int PAL_TOTAL    = 313,
  parameter int NTSC_RESUME  = 229,
  parameter int PAL_RESUME   = 202
) (
  input  logic [IDX_W-1:0]   idx,
  input  frame_mode_e        mode,
  output logic [COUNT_W-1:0] count,
  output logic               vblank
);

  localparam int SPAN = 1 << COUNT_W;
  // distance the count falls back by, and the line index where it resumes
  localparam logic [IDX_W-1:0] NTSC_BACK = IDX_W'(NTSC_TOTAL - SPAN);
  localparam logic [IDX_W-1:0] PAL_BACK  = IDX_W'(PAL_TOTAL - SPAN);
  localparam logic [IDX_W-1:0] NTSC_JUMP = IDX_W'(NTSC_RESUME + NTSC_TOTAL - SPAN);
  localparam logic [IDX_W-1:0] PAL_JUMP  = IDX_W'(PAL_RESUME + PAL_TOTAL - SPAN);
  localparam logic [IDX_W-1:0] NTSC_LAST = IDX_W'(NTSC_TOTAL - 1);
  localparam logic [IDX_W-1:0] PAL_LAST  = IDX_W'(PAL_TOTAL - 1);
  localparam logic [IDX_W-1:0] ACT_END   = IDX_W'(ACTIVE_LINES);

  logic [IDX_W-1:0] back, jump, last, shifted;

  always_comb begin
    back    = (mode == MODE_50HZ) ? PAL_BACK : NTSC_BACK;
    jump    = (mode == MODE_50HZ) ? PAL_JUMP : NTSC_JUMP;
    last    = (mode == MODE_50HZ) ? PAL_LAST : NTSC_LAST;
    shifted = idx - back;
    count   = (idx >= jump) ? shifted[COUNT_W-1:0] : idx[COUNT_W-1:0];
    vblank  = (idx >= ACT_END) && (idx != last);
  end

endmodule

// File: rtl/vline_status.sv
module vline_status
  import vline_pkg::*;
(
  input  frame_mode_e         mode,
  input  logic                hblank,
  input  logic                vblank,
  output logic [STATUS_W-1:0] status
);

  for (genvar b = 0; b < STATUS_W; b++) begin : g_bit
    if (b == ST_PAL_BIT) begin : g_pal
      assign status[b] = (mode == MODE_50HZ);
    end else if (b == ST_HB_BIT) begin : g_hb
      assign status[b] = hblank;
    end else if (b == ST_VB_BIT) begin : g_vb
      assign status[b] = vblank;
    end else begin : g_zero
      assign status[b] = 1'b0;
    end
  end

endmodule

// File: rtl/vline_counter.sv
module vline_counter
  import vline_pkg::*;
#(
  parameter int COUNT_W      = 8,
  parameter int ACTIVE_LINES = 224,
  parameter int NTSC_TOTAL   = 262,
  parameter int PAL_TOTAL    = 313,
  parameter int NTSC_RESUME  = 229,
  parameter int PAL_RESUME   = 202
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_adv,
  input  logic                pal_sel,
  input  logic                hblank,
  output logic [COUNT_W-1:0]  vcount,
  output logic                vblank,
  output logic                frame_start,
  output logic [STATUS_W-1:0] status
);

  localparam int MAX_TOTAL = (PAL_TOTAL > NTSC_TOTAL) ? PAL_TOTAL : NTSC_TOTAL;
  localparam int IDX_W     = $clog2(MAX_TOTAL);

  logic             rst_n_sync;
  logic [IDX_W-1:0] idx;
  frame_mode_e      mode;

  vline_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  vline_index #(
    .NTSC_TOTAL (NTSC_TOTAL),
    .PAL_TOTAL  (PAL_TOTAL),
    .IDX_W      (IDX_W)
  ) u_index (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .line_adv    (line_adv),
    .pal_sel     (pal_sel),
    .idx         (idx),
    .mode        (mode),
    .frame_start (frame_start)
  );

  vline_map #(
    .COUNT_W      (COUNT_W),
    .IDX_W        (IDX_W),
    .ACTIVE_LINES (ACTIVE_LINES),
    .NTSC_TOTAL   (NTSC_TOTAL),
    .PAL_TOTAL    (PAL_TOTAL),
    .NTSC_RESUME  (NTSC_RESUME),
    .PAL_RESUME   (PAL_RESUME)
  ) u_map (
    .idx    (idx),
    .mode   (mode),
    .count  (vcount),
    .vblank (vblank)
  );

  vline_status u_status (
    .mode   (mode),
    .hblank (hblank),
    .vblank (vblank),
    .status (status)
  );

  AST_VB_RISE_AT_ACTIVE_END: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(vblank) |-> (vcount == COUNT_W'(ACTIVE_LINES))); // R5
  AST_VB_FALL_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $fell(vblank) |-> (vcount == '1)); // R5
  AST_FRAME_AT_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n_sync)
    frame_start |-> (vcount == '0 && !vblank)); // R6
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !line_adv |=> $stable(vcount)); // R2

endmodule

// File: tb/vline_counter_test.sv
module vline_counter_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        line_adv;
  logic        pal_sel;
  logic        hblank;
  logic [7:0]  vcount;
  logic        vblank;
  logic        frame_start;
  logic [15:0] status;

  int checks = 0;
  int fails  = 0;

  // sequence model state
  logic [7:0] e_cnt;
  bit         e_vb, e_jmp, e_pal, e_fs;

  always #4 clk = ~clk;

  vline_counter uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_adv    (line_adv),
    .pal_sel     (pal_sel),
    .hblank      (hblank),
    .vcount      (vcount),
    .vblank      (vblank),
    .frame_start (frame_start),
    .status      (status)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_status();
    return {28'd0, e_vb, hblank, 1'b0, e_pal};
  endfunction

  task automatic model_step();
    e_fs = 1'b0;
    if (e_jmp && !e_vb && e_cnt == 8'hFF) begin
      e_cnt = 8'h00; e_vb = 1'b0; e_jmp = 1'b0; e_pal = pal_sel; e_fs = 1'b1;
    end else if (!e_jmp && ((!e_pal && e_cnt == 8'hEA) ||
                            (e_pal && e_vb && e_cnt == 8'h02))) begin
      e_cnt = e_pal ? 8'hCA : 8'hE5;
      e_jmp = 1'b1;
    end else begin
      e_cnt = e_cnt + 8'd1;
      if (!e_jmp && e_cnt == 8'd224) e_vb = 1'b1;
      if (e_jmp && e_cnt == 8'hFF)   e_vb = 1'b0;
    end
  endtask

  task automatic adv();
    @(negedge clk) line_adv = 1'b1;
    @(negedge clk) line_adv = 1'b0;
    model_step();
  endtask

  task automatic check_line(input string seq_req);
    chk(seq_req, vcount, e_cnt);
    chk("R5 vblank", vblank, e_vb);
    chk("R6 frame_start", frame_start, e_fs);
    chk("R8 status", status, exp_status());
  endtask

  // runs one frame from line 0, switching pal_sel after switch_at lines
  task automatic run_frame(input string seq_req, input int exp_lines,
                           input int switch_at, input bit new_sel);
    int n = 0;
    int zero_in_vb = 0;
    do begin
      if (n == switch_at && switch_at > 0) begin
        pal_sel = new_sel;
        @(negedge clk);
        chk("R7 status bit0 held mid-frame", status[0], e_pal);
      end
      adv();
      n++;
      check_line(seq_req);
      if (vcount == 8'h00 && vblank) zero_in_vb++;
    end while (!e_fs && n < 400);
    chk({seq_req, " frame length"}, n, exp_lines);
    chk("R5 zero count inside vblank", zero_in_vb, (exp_lines == 313) ? 1 : 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; line_adv = 1'b0; pal_sel = 1'b0; hblank = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 count in reset", vcount, 0);
    chk("R1 vblank in reset", vblank, 0);
    chk("R1 frame_start in reset", frame_start, 0);
    chk("R1 status in reset", status, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 count after reset", vcount, 0);
    chk("R1 status after reset", status, 0);
    e_cnt = 8'h00; e_vb = 1'b0; e_jmp = 1'b0; e_pal = 1'b0; e_fs = 1'b0;
  endtask

  task automatic t_idle_hblank();
    adv(); adv(); adv();
    check_line("R2 pre-idle count");
    hblank = 1'b1;
    repeat (5) @(negedge clk);
    chk("R2 count held without strobe", vcount, 3);
    chk("R8 hblank in bit2", status, exp_status());
    hblank = 1'b0;
    #1;
    chk("R8 hblank released", status[2], 0);
  endtask

  task automatic t_pulse_width();
    @(negedge clk);
    chk("R6 pulse one clock wide", frame_start, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_idle_hblank();
    // finish the first 60 Hz frame (3 lines already done), select 50 Hz mid-frame
    begin
      int n = 3;
      do begin
        if (n == 100) begin
          pal_sel = 1'b1;
          @(negedge clk);
          chk("R7 status bit0 held mid-frame", status[0], 0);
        end
        adv();
        n++;
        check_line("R3 60Hz count");
      end while (!e_fs && n < 400);
      chk("R3 frame length", n, 262);
    end
    chk("R7 50Hz active after frame start", status[0], 1);
    t_pulse_width();
    run_frame("R4 50Hz count", 313, 150, 1'b0);
    chk("R7 60Hz active after frame start", status[0], 0);
    t_pulse_width();
    run_frame("R3 60Hz count", 262, 0, 1'b0);
    t_pulse_width();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule